// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block is a read/write data cache that sits between a processor load/store port and a word-wide memory port. It holds 16 KB of data as four ways of 1024 one-word lines. Each line has a valid bit, a dirty bit, a 20-bit tag and a 32-bit word. A processor request indexes one set. The tags of all four ways in that set are compared at the same time. A hit completes in the same cycle: read data comes through a four-input selector and write data is merged under byte enables.

On a miss the processor port stalls. The controller chooses a victim way: an empty way if the set has one, otherwise the least-recently-used way, which comes from a per-set ranking unit. If the victim holds modified data, it is written back to memory first. The line is then refilled with one memory read. After that the held request completes as a hit. Writes allocate on a miss, so a write miss refills the line and then merges the new bytes into it.

Top module: `cache_top`

## Requirements
- R1: A byte address splits into tag = addr[31:12], set = addr[11:2] and byte offset = addr[1:0]. The offset has no effect on lookup, so addresses that differ only in bits 1:0 reach the same word.
- R2: A way hits when its line is valid and its stored tag equals the address tag. `cpu_hit` is the OR of the four way hits. On a read hit, `cpu_rdata` carries the hitting way's word, and `cpu_ready` is high in the same cycle as the request.
- R3: After reset every line is invalid and clean. The first access to any address misses, and with no request `cpu_ready` is 1 and `mem_req` is 0.
- R4: A miss holds `cpu_ready` and `cpu_hit` low from the cycle the miss is seen until the refill read is acknowledged. The stall lasts one cycle plus the duration of each memory transaction. In the cycle after the refill the held request completes as a hit.
- R5: When the indexed set has one or more invalid ways, the victim is the lowest-numbered invalid way.
- R6: When all four ways are valid, the victim is the way used least recently. Use means a hit, and the hit that follows each refill counts as one.
- R7: A write hit replaces byte i of the word (bits 8i+7:8i) only where `cpu_be[i]` is 1, and it marks the line dirty.
- R8: Evicting a valid dirty line first issues a memory write of the old word to {old tag, set, 2'b00}. The refill read is issued only after that write is acknowledged.
- R9: A write miss refills the line from memory and then applies the byte-enabled write to the refilled word.
- R10: Evicting a clean or invalid line issues no memory write. The refill read goes to {tag, set, 2'b00}, and the refilled line starts clean.
- R11: `mem_req`, `mem_we` and `mem_addr` stay stable from the start of a memory transaction until `mem_ack`, and the block has at most one transaction outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the hitting way |
| cpu_hit | output | 1 | Request hits this cycle |
| cpu_ready | output | 1 | Request completes this cycle (low while stalled) |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle completion of a memory transaction |
| mem_rdata | input | 32 | Refill data, valid with `mem_ack` |

## Verification
Hit results (`cpu_hit`, `cpu_ready`, `cpu_rdata`) are combinational and are due in the same cycle as the request. The bench samples them 1 ns after the falling edge on which it drives the request. A miss stalls for one cycle plus three cycles per memory transaction under the bench's two-cycle memory latency. The bench counts the low-ready cycles at every falling edge, checks that `cpu_hit` stays low throughout, and then compares the completing hit cycle against its timestamp-ordered model. Write-back and refill addresses and data are logged at the memory acknowledge and compared in order against what the model predicts for each miss.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } ctl_state_e;

  // byte-lane merge: lane i taken from new_w when be[i] is set
  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < BE_W; i++)
      if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cache_way_store.sv
module cache_way_store #(
  parameter int SETS  = 1024,
  parameter int TAG_W = 20,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WORD_W-1:0] data_o
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [WORD_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (wr_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= fill_tag;
      data_q[idx] <= fill_data;
    end else if (wr_en) begin
      data_q[idx] <= wr_data;
    end
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign tag_o   = tag_q[idx];
  assign data_o  = data_q[idx];
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS = 1024,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);
  localparam int VEC_W = WAYS * WAY_W;

  // rank per way: WAYS-1 = most recent, 0 = least recent
  logic [VEC_W-1:0] rank_q [SETS];
  logic [VEC_W-1:0] cur_vec, next_vec;
  logic [WAY_W-1:0] touched_rank;

  function automatic logic [VEC_W-1:0] initial_ranks();
    logic [VEC_W-1:0] v;
    for (int w = 0; w < WAYS; w++) v[w*WAY_W +: WAY_W] = WAY_W'(w);
    return v;
  endfunction

  assign cur_vec = rank_q[set_idx];

  always_comb begin
    touched_rank = '0;
    for (int w = 0; w < WAYS; w++)
      if (w == int'(touch_way)) touched_rank = cur_vec[w*WAY_W +: WAY_W];
    next_vec = cur_vec;
    for (int w = 0; w < WAYS; w++) begin
      if (w == int'(touch_way))
        next_vec[w*WAY_W +: WAY_W] = WAY_W'(WAYS - 1);
      else if (cur_vec[w*WAY_W +: WAY_W] > touched_rank)
        next_vec[w*WAY_W +: WAY_W] = cur_vec[w*WAY_W +: WAY_W] - 1'b1;
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (cur_vec[w*WAY_W +: WAY_W] == '0) lru_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rank_q[s] <= initial_ranks();
    end else if (touch_en) begin
      rank_q[set_idx] <= next_vec;
    end
  end
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim_way
);
  logic             any_empty;
  logic [WAY_W-1:0] empty_way;

  always_comb begin
    any_empty = 1'b0;
    empty_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) begin
        any_empty = 1'b1;
        empty_way = WAY_W'(w);
      end
  end

  assign victim_way = any_empty ? empty_way : lru_way;
endmodule

// File: rtl/cache_top.sv
module cache_top
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 1024,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(BE_W);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  ctl_state_e        state_q;
  logic [TAG_W-1:0]  req_tag, miss_tag_q, wb_tag_q;
  logic [IDX_W-1:0]  req_set, set_q, store_set;
  logic [WAY_W-1:0]  victim_way, victim_q, lru_way, hit_way;
  logic [WORD_W-1:0] wb_data_q, merged_word;

  logic [WAYS-1:0]   way_valid, way_dirty, way_hit, fill_vec, wr_vec;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [WORD_W-1:0] way_data [WAYS];

  // named internal events
  logic lookup_hit, miss_start, fill_en;

  assign req_tag   = addr_tag(cpu_addr);
  assign req_set   = addr_set(cpu_addr);
  assign store_set = (state_q == ST_LOOKUP) ? req_set : set_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_way_store #(.SETS(SETS), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (store_set),
      .fill_en  (fill_vec[w]),
      .fill_tag (miss_tag_q),
      .fill_data(mem_rdata),
      .wr_en    (wr_vec[w]),
      .wr_data  (merged_word),
      .valid_o  (way_valid[w]),
      .dirty_o  (way_dirty[w]),
      .tag_o    (way_tag[w]),
      .data_o   (way_data[w])
    );
    assign way_hit[w]  = way_valid[w] && (way_tag[w] == req_tag);
    assign fill_vec[w] = fill_en && (victim_q == WAY_W'(w));
    assign wr_vec[w]   = lookup_hit && cpu_we && way_hit[w];
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = WAY_W'(w);
  end

  assign lookup_hit  = (state_q == ST_LOOKUP) && cpu_req && (|way_hit);
  assign miss_start  = (state_q == ST_LOOKUP) && cpu_req && !(|way_hit);
  assign fill_en     = (state_q == ST_REFILL) && mem_ack;
  assign merged_word = merge_bytes(way_data[hit_way], cpu_wdata, cpu_be);

  cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_idx  (store_set),
    .touch_en (lookup_hit),
    .touch_way(hit_way),
    .lru_way  (lru_way)
  );

  cache_victim #(.WAYS(WAYS)) u_victim (
    .way_valid (way_valid),
    .lru_way   (lru_way),
    .victim_way(victim_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_LOOKUP;
      victim_q   <= '0;
      set_q      <= '0;
      miss_tag_q <= '0;
      wb_tag_q   <= '0;
      wb_data_q  <= '0;
    end else begin
      case (state_q)
        ST_LOOKUP: if (miss_start) begin
          victim_q   <= victim_way;
          set_q      <= req_set;
          miss_tag_q <= req_tag;
          wb_tag_q   <= way_tag[victim_way];
          wb_data_q  <= way_data[victim_way];
          state_q    <= (way_valid[victim_way] && way_dirty[victim_way])
                        ? ST_EVICT : ST_REFILL;
        end
        ST_EVICT:  if (mem_ack) state_q <= ST_REFILL;
        ST_REFILL: if (mem_ack) state_q <= ST_LOOKUP;
        default:   state_q <= ST_LOOKUP;
      endcase
    end
  end

  assign cpu_hit   = lookup_hit;
  assign cpu_ready = (state_q == ST_LOOKUP) && (!cpu_req || lookup_hit);
  assign cpu_rdata = way_data[hit_way];
  assign mem_req   = (state_q != ST_LOOKUP);
  assign mem_we    = (state_q == ST_EVICT);
  assign mem_addr  = (state_q == ST_EVICT) ? line_addr(wb_tag_q, set_q)
                                           : line_addr(miss_tag_q, set_q);
  assign mem_wdata = wb_data_q;
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_hit,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WAYS-1:0]   way_hit,
  input logic              fill_en
);
  logic filled_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       filled_q <= 1'b0;
    else if (fill_en) filled_q <= 1'b1;
  end

  // R3: no hit before the first refill
  assert_no_early_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> filled_q);

  // R2: at most one way matches a set
  assert_single_way_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R4: a pending request completes only as a hit
  assert_ready_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |-> cpu_hit);

  // R4: held request hits right after its refill
  assert_hit_after_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && cpu_req) |=> cpu_hit);

  // R11: transaction held stable until acknowledged
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R8: write-back is followed by the refill read
  assert_wb_then_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

bind cache_top cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_req  (cpu_req),
  .cpu_hit  (cpu_hit),
  .cpu_ready(cpu_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .way_hit  (way_hit),
  .fill_en  (fill_en)
);

// File: tb/sim_cache_top.sv
`timescale 1ns/1ps
module sim_cache_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic        cpu_hit, cpu_ready, mem_req, mem_we;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  cache_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int nvec = 0, nbad = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // ---------- backing memory and responder ----------
  logic [31:0] bmem [logic [31:0]];
  logic        log_we   [$];
  logic [31:0] log_addr [$];
  logic [31:0] log_data [$];
  int wcnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return (a * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt == LAT) begin
        wcnt = 0;
        mem_ack = 1'b1;
        log_we.push_back(mem_we);
        log_addr.push_back(mem_addr);
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          log_data.push_back(mem_wdata);
        end else begin
          mem_rdata = mem_word(mem_addr);
          log_data.push_back(mem_rdata);
        end
      end else wcnt++;
    end
  end

  // ---------- reference model: timestamps per line ----------
  bit          mv [1024][4];
  bit          md [1024][4];
  logic [19:0] mt [1024][4];
  logic [31:0] mdat [1024][4];
  int          mstamp [1024][4];
  int          now = 0;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  task automatic access(input bit we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input string r);
    int s = int'(a[11:2]);
    logic [19:0] t = a[31:12];
    int hw = -1, vw = -1, ntr = 0, stalls = 0;
    bit exp_wb = 0;
    logic [31:0] wb_a = '0, wb_d = '0;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
    if (hw < 0) begin
      for (int w = 3; w >= 0; w--) if (!mv[s][w]) vw = w;
      if (vw < 0) begin
        vw = 0;
        for (int w = 1; w < 4; w++) if (mstamp[s][w] < mstamp[s][vw]) vw = w;
      end
      exp_wb = mv[s][vw] && md[s][vw];
      wb_a = {mt[s][vw], a[11:2], 2'b00};
      wb_d = mdat[s][vw];
      ntr = exp_wb ? 2 : 1;
    end
    log_we.delete(); log_addr.delete(); log_data.delete();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    #1;
    while (!cpu_ready && stalls < 100) begin
      chk(cpu_hit == 1'b0, {r, " R4 hit low while stalled"}, 32'(cpu_hit), 0);
      stalls++;
      @(negedge clk); #1;
    end
    if (hw < 0) begin
      chk(stalls == 1 + 3 * ntr, {r, " R4 stall cycles"}, stalls, 1 + 3 * ntr);
      chk(log_we.size() == ntr, {r, " R10/R8 transaction count"}, log_we.size(), ntr);
      if (log_we.size() == ntr) begin
        if (exp_wb) begin
          chk(log_we[0] == 1'b1 && log_addr[0] == wb_a, {r, " R8 write-back address"}, log_addr[0], wb_a);
          chk(log_data[0] == wb_d, {r, " R8 write-back data"}, log_data[0], wb_d);
        end
        chk(log_we[ntr-1] == 1'b0 && log_addr[ntr-1] == {t, a[11:2], 2'b00},
            {r, " R10 refill address"}, log_addr[ntr-1], {t, a[11:2], 2'b00});
      end
      mv[s][vw] = 1; md[s][vw] = 0; mt[s][vw] = t;
      mdat[s][vw] = mem_word({t, a[11:2], 2'b00});
      hw = vw;
    end else begin
      chk(stalls == 0, {r, " R2 hit completes same cycle"}, stalls, 0);
    end
    chk(cpu_hit == 1'b1 && cpu_ready == 1'b1, {r, " R2 hit and ready"}, {cpu_hit, cpu_ready}, 2'b11);
    if (!we) chk(cpu_rdata == mdat[s][hw], {r, " R2 read data"}, cpu_rdata, mdat[s][hw]);
    else begin
      mdat[s][hw] = merge(mdat[s][hw], wd, be);
      md[s][hw] = 1;
    end
    now++;
    mstamp[s][hw] = now;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic expect_hit_state(input logic [31:0] a, input bit exp, input string r);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1;
    chk(cpu_hit == exp, r, 32'(cpu_hit), 32'(exp));
    cpu_req = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3: idle outputs after reset
    chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R3 idle after reset", {cpu_ready, mem_req}, 2'b10);
    // R3: first access misses (stall count checked inside)
    expect_hit_state(32'h0000_1000, 1'b0, "R3 no hit right after reset");
    access(0, 32'h0000_1000, 4'h0, 0, "R3/R10 first read");
    // R1: byte offset ignored
    access(0, 32'h0000_1003, 4'h0, 0, "R1 offset alias");
    // R5: fill set 5 with four tags, empty ways taken first
    for (int k = 1; k <= 4; k++) access(0, (32'(k) << 12) | (32'd5 << 2), 4'h0, 0, "R5 fill empty way");
    for (int k = 1; k <= 4; k++) access(0, (32'(k) << 12) | (32'd5 << 2), 4'h0, 0, "R2 hit each way");
    // R6: reorder use, tag 2 becomes least recent
    access(0, (32'd3 << 12) | (32'd5 << 2), 4'h0, 0, "R6 touch");
    access(0, (32'd1 << 12) | (32'd5 << 2), 4'h0, 0, "R6 touch");
    access(0, (32'd4 << 12) | (32'd5 << 2), 4'h0, 0, "R6 touch");
    access(0, (32'd9 << 12) | (32'd5 << 2), 4'h0, 0, "R6 evict lru");
    expect_hit_state((32'd2 << 12) | (32'd5 << 2), 1'b0, "R6 evicted tag now misses");
    // R1: tag bit 31 distinguishes lines
    expect_hit_state(32'h8000_1000 | (32'd5 << 2), 1'b0, "R1 upper tag bit compared");
    // R7: byte-enabled write hit then read back
    access(1, (32'd1 << 12) | (32'd5 << 2), 4'b0101, 32'hAABB_CCDD, "R7 write hit");
    access(0, (32'd1 << 12) | (32'd5 << 2), 4'h0, 0, "R7 read merged");
    access(1, (32'd1 << 12) | (32'd5 << 2), 4'b1000, 32'h1100_0000, "R7 second write");
    // R8: push the dirty line out with new tags
    for (int k = 20; k < 25; k++) access(0, (32'(k) << 12) | (32'd5 << 2), 4'h0, 0, "R8 pressure");
    access(0, (32'd1 << 12) | (32'd5 << 2), 4'h0, 0, "R8 reread after write-back");
    // R9: write miss allocates then writes
    access(1, (32'h55 << 12) | (32'd7 << 2), 4'b1000, 32'hEE00_0000, "R9 write miss");
    access(0, (32'h55 << 12) | (32'd7 << 2), 4'h0, 0, "R9 read after write miss");
    // R2: other sets undisturbed
    access(0, 32'h0000_1000, 4'h0, 0, "R2 set 0 still resident");
    // R8: dirty eviction in set 7
    for (int k = 60; k < 64; k++) access(0, (32'(k) << 12) | (32'd7 << 2), 4'h0, 0, "R8 set 7 pressure");
    // R11: mixed dirty traffic across sets
    for (int k = 0; k < 12; k++)
      access(k[0], (32'(k + 100) << 12) | (32'(k % 3) << 2), 4'b0011, 32'(k * 7919), "R11 mixed");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule